// File: doc/BRIEF.md
# Pipelined Carry-Save Multiplier

This block multiplies two unsigned 4-bit operands and returns the full 8-bit product through a four-stage pipeline. The first stage forms one shifted row per multiplier bit by gating the multiplicand with that bit. The next two stages compress these rows with three-input carry-save adders arranged as a small Wallace tree. These adders keep the column carries in a separate vector and never ripple them. The last stage resolves the final sum and carry pair with a carry-propagate adder and registers the product.

The input side is a stream with a valid flag and no ready signal. The block is always able to accept data, so it never asserts back-pressure, and an upstream source may present a new pair on every clock. Each pair travels with its own valid bit. A cycle with the valid flag low forms a bubble that reaches the output intact. While a bubble is at the output the product register keeps its last value. Downstream logic must take every valid result in the cycle it appears, because nothing holds a result back.

Top module: `cs_mul_pipe`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product of the `in_a` and `in_b` that entered with that result, in all 8 bits with no truncation.
- R2: A pair sampled with `in_valid` high at a rising edge shows `out_valid` high and its product after the fourth rising edge, counting the edge that sampled it as the first.
- R3: Pairs presented on consecutive clocks give results on consecutive clocks, one product per cycle, with no cycle lost between them.
- R4: `out_valid` repeats the `in_valid` pattern delayed by exactly four edges, so a bubble at the input gives `out_valid` low in the matching output cycle.
- R5: An edge sampled with `rst` high clears all valid flags and the product register to 0. `in_valid` is ignored during reset, and after reset `out_valid` stays low until a pair sampled after reset reaches the output.
- R6: While `out_valid` is low, `out_prod` holds the last product delivered, or 0 if no product has been delivered since reset.
- R7: The operand extremes are exact: zero with any operand gives 0, 15 times 15 gives 225 (0xE1), and an operand of 1 passes the other operand through unchanged.
- R8: Each carry-save stage preserves the arithmetic value modulo 256. The sum vector plus the carry vector of stage 3 equals the sum plus carry plus the passed row of stage 2 from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operand pair on this cycle |
| in_a | input | 4 | Multiplicand, unsigned |
| in_b | input | 4 | Multiplier, unsigned |
| out_valid | output | 1 | Product on `out_prod` is new this cycle |
| out_prod | output | 8 | Unsigned product |

## Verification
A table of hand-picked pairs covers zero, all-ones, one-hot and mixed operands. These pairs separate faults in row gating and shifting from faults in the carry paths, because only the mixed and all-ones cases drive carries through several columns. All 256 pairs are then issued back-to-back to show that no operand combination and no run of successive pairs corrupts a result. An alternating valid and bubble pattern shows that the valid flag and the product hold behave correctly. A reset asserted while the pipeline is full, with `in_valid` kept high, shows that in-flight pairs are discarded rather than delivered late.

// File: rtl/cs_mul_pkg.sv
package cs_mul_pkg;
  // Operand width; the reduction tree below is shaped for this many rows.
  localparam int unsigned MUL_OP_W   = 4;
  localparam int unsigned MUL_PROD_W = 2 * MUL_OP_W;
  // Number of partial-product rows entering the tree.
  localparam int unsigned MUL_ROWS   = MUL_OP_W;

  typedef logic [MUL_PROD_W-1:0] mul_vec_t;
endpackage

// File: rtl/cs_mul_pp_gen.sv
module cs_mul_pp_gen #(
  parameter int unsigned OP_W = 4,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]              mcand,
  input  logic [OP_W-1:0]              mplier,
  output logic [OP_W-1:0][PROD_W-1:0]  rows
);
  // One row per multiplier bit: gated multiplicand shifted to the bit weight.
  for (genvar r = 0; r < OP_W; r++) begin : g_row
    logic [PROD_W-1:0] gated;
    assign gated   = {{OP_W{1'b0}}, (mcand & {OP_W{mplier[r]}})};
    assign rows[r] = gated << r;
  end
endmodule

// File: rtl/cs_mul_csa.sv
module cs_mul_csa #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  // Column-local compression: no signal crosses from one column to the next
  // except the saved carry, which simply moves one place left.
  for (genvar i = 0; i < W; i++) begin : g_col
    assign sum[i] = x[i] ^ y[i] ^ z[i];
  end
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W - 1; i++) begin : g_cy
    assign carry[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end
endmodule

// File: rtl/cs_mul_cpa.sv
module cs_mul_cpa #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ cy[i];
    if (i < W - 1) begin : g_next
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/cs_mul_pipe.sv
module cs_mul_pipe
  import cs_mul_pkg::*;
#(
  parameter int unsigned OP_W = MUL_OP_W,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_prod
);
  // ---------------- stage 1: partial products ----------------
  logic [OP_W-1:0][PROD_W-1:0] rows_d;
  logic [OP_W-1:0][PROD_W-1:0] rows_q;
  logic                        st1_valid;

  cs_mul_pp_gen #(.OP_W(OP_W)) u_pp (
    .mcand  (in_a),
    .mplier (in_b),
    .rows   (rows_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_valid <= 1'b0;
      rows_q    <= '0;
    end else begin
      st1_valid <= in_valid;
      if (in_valid) rows_q <= rows_d;
    end
  end

  // ---------------- stage 2: first carry-save level ----------------
  logic [PROD_W-1:0] l1_sum, l1_carry;
  logic [PROD_W-1:0] st2_sum, st2_carry, st2_pass;
  logic              st2_valid;

  cs_mul_csa #(.W(PROD_W)) u_csa_l1 (
    .x     (rows_q[0]),
    .y     (rows_q[1]),
    .z     (rows_q[2]),
    .sum   (l1_sum),
    .carry (l1_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st2_valid <= 1'b0;
      st2_sum   <= '0;
      st2_carry <= '0;
      st2_pass  <= '0;
    end else begin
      st2_valid <= st1_valid;
      if (st1_valid) begin
        st2_sum   <= l1_sum;
        st2_carry <= l1_carry;
        st2_pass  <= rows_q[3];
      end
    end
  end

  // ---------------- stage 3: second carry-save level ----------------
  logic [PROD_W-1:0] l2_sum, l2_carry;
  logic [PROD_W-1:0] st3_sum, st3_carry;
  logic              st3_valid;

  cs_mul_csa #(.W(PROD_W)) u_csa_l2 (
    .x     (st2_sum),
    .y     (st2_carry),
    .z     (st2_pass),
    .sum   (l2_sum),
    .carry (l2_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st3_valid <= 1'b0;
      st3_sum   <= '0;
      st3_carry <= '0;
    end else begin
      st3_valid <= st2_valid;
      if (st2_valid) begin
        st3_sum   <= l2_sum;
        st3_carry <= l2_carry;
      end
    end
  end

  // ---------------- stage 4: carry-propagate resolve ----------------
  logic [PROD_W-1:0] resolved;

  cs_mul_cpa #(.W(PROD_W)) u_cpa (
    .a   (st3_sum),
    .b   (st3_carry),
    .sum (resolved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= st3_valid;
      if (st3_valid) out_prod <= resolved;
    end
  end
endmodule

// File: rtl/cs_mul_pipe_chk.sv
module cs_mul_pipe_chk #(
  parameter int unsigned OP_W = 4,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_a,
  input logic [OP_W-1:0]   in_b,
  input logic              out_valid,
  input logic [PROD_W-1:0] out_prod,
  input logic              st2_valid,
  input logic [PROD_W-1:0] st2_sum,
  input logic [PROD_W-1:0] st2_carry,
  input logic [PROD_W-1:0] st2_pass,
  input logic [PROD_W-1:0] st3_sum,
  input logic [PROD_W-1:0] st3_carry
);
  // Edges seen since reset, saturating at the pipeline depth.
  logic [2:0] since;
  always_ff @(posedge clk) begin
    if (rst)               since <= 3'd0;
    else if (since != 3'd4) since <= since + 3'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_prod == '0)); // R5

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R4

  AST_LATENCY_FOUR: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4 && $past(in_valid, 4)) |-> out_valid); // R2

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4 && $past(in_valid, 4)) |->
      (out_prod == PROD_W'(PROD_W'($past(in_a, 4)) * PROD_W'($past(in_b, 4))))); // R1

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd4 && $past(in_valid, 4) && $past(in_valid, 3)) |=> out_valid); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (since != 3'd0 && !out_valid) |-> $stable(out_prod)); // R6

  AST_CSA_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    (since != 3'd0 && $past(st2_valid)) |->
      (PROD_W'(st3_sum + st3_carry) ==
       PROD_W'($past(st2_sum) + $past(st2_carry) + $past(st2_pass)))); // R8
endmodule

bind cs_mul_pipe cs_mul_pipe_chk #(.OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .st2_valid (st2_valid),
  .st2_sum   (st2_sum),
  .st2_carry (st2_carry),
  .st2_pass  (st2_pass),
  .st3_sum   (st3_sum),
  .st3_carry (st3_carry)
);

// File: tb/test_cs_mul_pipe.sv
module test_cs_mul_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int NVEC       = 12;

  // {a, b, expected product}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'h0, 4'h0, 8'h00}, {4'hF, 4'hF, 8'hE1}, {4'h1, 4'hF, 8'h0F},
    {4'hF, 4'h1, 8'h0F}, {4'h8, 4'h8, 8'h40}, {4'hA, 4'h5, 8'h32},
    {4'h7, 4'h9, 8'h3F}, {4'h0, 4'hF, 8'h00}, {4'hC, 4'h3, 8'h24},
    {4'h5, 4'h5, 8'h19}, {4'h9, 4'hE, 8'h7E}, {4'h6, 4'hB, 8'h42}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_a = '0;
  logic [3:0] in_b = '0;
  logic       out_valid;
  logic [7:0] out_prod;

  int errors = 0;
  int checks = 0;

  // Expected-result history: index 0 is the pair driven most recently.
  logic       hv [DEPTH];
  logic [7:0] hp [DEPTH];
  string      ht [DEPTH];
  logic [7:0] last_prod = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_mul_pipe i_cs_mul_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  task automatic clear_hist();
    for (int i = 0; i < DEPTH; i++) begin
      hv[i] = 1'b0;
      hp[i] = '0;
      ht[i] = "R5";
    end
    last_prod = '0;
  endtask

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: valid/prod actual=%0b/%0h expected=%0b/%0h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // At a falling edge: check the output due for the pair driven DEPTH steps
  // ago, then drive a new pair.
  task automatic step(logic v, logic [3:0] a, logic [3:0] b, string tag);
    @(negedge clk);
    if (hv[DEPTH-1]) begin
      last_prod = hp[DEPTH-1];
      check(ht[DEPTH-1], {out_valid, out_prod}, {1'b1, last_prod});
    end else begin
      check({ht[DEPTH-1], "/R4/R6"}, {out_valid, out_prod}, {1'b0, last_prod});
    end
    for (int i = DEPTH - 1; i > 0; i--) begin
      hv[i] = hv[i-1];
      hp[i] = hp[i-1];
      ht[i] = ht[i-1];
    end
    hv[0] = v;
    hp[0] = 8'(a) * 8'(b);
    ht[0] = tag;
    in_valid = v;
    in_a = a;
    in_b = b;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5", {out_valid, out_prod}, 9'h000);
    rst = 1'b0;

    // R1 R7: table of corner vectors, back-to-back
    for (int k = 0; k < NVEC; k++) begin
      step(1'b1, VEC[k][15:12], VEC[k][11:8], "R1/R7");
      if (hp[0] !== VEC[k][7:0]) begin
        errors++;
        $display("FAIL R7: table entry %0d actual=%0h expected=%0h", k, hp[0], VEC[k][7:0]);
      end
    end
    for (int k = 0; k < DEPTH; k++) step(1'b0, 4'h0, 4'h0, "R4");

    // R3 R8 R1 R2: all 256 pairs without gaps
    for (int i = 0; i < 256; i++) begin
      logic [7:0] idx = 8'(i);
      step(1'b1, idx[7:4], idx[3:0], "R2/R3");
    end
    for (int k = 0; k < DEPTH; k++) step(1'b0, 4'h3, 4'h3, "R6");

    // R4 R6: alternating valid and bubble with junk operands on bubbles
    for (int k = 0; k < 16; k++) begin
      if (k % 2 == 0) step(1'b1, 4'(k), 4'(15 - k), "R4");
      else            step(1'b0, 4'hF, 4'hF, "R6");
    end

    // R5: reset with a full pipeline and in_valid held high
    for (int k = 0; k < DEPTH; k++) step(1'b1, 4'hD, 4'h7, "R1");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R5", {out_valid, out_prod}, 9'h000);
    @(negedge clk);
    check("R5", {out_valid, out_prod}, 9'h000);
    rst = 1'b0;
    in_valid = 1'b0;
    clear_hist();
    for (int k = 0; k < DEPTH; k++) step(1'b0, 4'hE, 4'hE, "R5");
    step(1'b1, 4'hB, 4'hD, "R1");
    for (int k = 0; k < DEPTH + 1; k++) step(1'b0, 4'h0, 4'h0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule